// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The block collects a parameterised number of level-sensitive interrupt sources, a multiple of 32 up to 512, and merges them onto a few output interrupt lines. Each output line covers one fixed group of 64 sources. Every source has three bits, one in each of three banks of 32-bit words: an enable (mask) bit, a software-forced request bit and a read-only status bit. The banks are laid out in reverse word order, so the word with the highest index holds sources 0 to 31.

Software reaches the block through a simple 32-bit register port. A write takes effect on the clock edge where it is requested. A read returns its data, together with a valid strobe, one cycle after the request. A channel-control register selects which channel is live, and the outputs are driven only while the channel bit wired to this instance is set. A per-output master-disable register can silence single lines. A master-status register shows each line's state before master disable is applied.

Top module: `irqst_agg`

## Requirements
- R1: With NW = NUM_IN/32 words per bank, source n sits in word NW-1-n/32 of each bank, at bit n mod 32.
- R2: Byte addresses: channel control at 0x0; mask word i at 0x4+4i; force word i at 4·NW+0x4+4i; status word i at 8·NW+0x4+4i; master disable at 12·NW+0x4; master status at 12·NW+0x8. Any other address reads as zero.
- R3: Mask and force words are fully readable and writable, and they return the full 32-bit value last written.
- R4: Channel control holds CHAN_W bits and reads back zero-extended. Every output stays low unless bit CHAN_SEL of channel control is 1.
- R5: A status bit equals (synchronised source OR force bit) AND mask bit. Writes to the status words are ignored.
- R6: Sources are level-sensitive. A status bit follows its enabled source while the source is high and clears when the source falls. A source whose mask bit is 0 has no effect on status or outputs.
- R7: Output k is the OR of the status bits of sources 64k to 64k+63. When NUM_IN is not a multiple of 64, the last group holds only 32 sources.
- R8: Synchronous reset clears channel control, mask, force, master disable, status and all outputs.
- R9: Master-disable bit k forces output k low and leaves the other outputs unaffected.
- R10: Master-status bit k reads the gated state of output k before master disable is applied.
- R11: Read data and a one-cycle valid strobe appear one cycle after a read request. A change on an enabled source reaches its output on the fourth rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_in | input | NUM_IN | Raw level interrupt sources |
| irq_out | output | NUM_OUT | Aggregated output lines |

## Verification
The bench builds the block with NUM_IN = 96 and CHAN_SEL = 2. This gives three words per bank and two outputs, and the second output covers only a half-size group of 32 sources. With these values the reversed word order can be checked at both ends of the range: source 0 in the last word, and sources 40 and 95 in the middle and first words. The partial last group, the scaled bank offsets and the unmapped address just past master status are all reachable. The choice of channel bit 2 means that writes selecting other channels can be shown to hold the outputs low.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  typedef enum logic [2:0] {
    RG_CTRL, RG_MASK, RG_FORCE, RG_STAT, RG_MDIS, RG_MSTAT, RG_NONE
  } region_e;
  typedef logic [31:0] word_t;
endpackage

// File: rtl/irqst_sync.sv
module irqst_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqst_dec.sv
module irqst_dec
  import irqst_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    int wa;
    wa     = int'(addr >> 2);
    region = RG_NONE;
    idx    = '0;
    if (wa == 0) begin
      region = RG_CTRL;
    end else if (wa <= NWORDS) begin
      region = RG_MASK;
      idx    = IDX_W'(wa - 1);
    end else if (wa <= 2 * NWORDS) begin
      region = RG_FORCE;
      idx    = IDX_W'(wa - 1 - NWORDS);
    end else if (wa <= 3 * NWORDS) begin
      region = RG_STAT;
      idx    = IDX_W'(wa - 1 - 2 * NWORDS);
    end else if (wa == 3 * NWORDS + 1) begin
      region = RG_MDIS;
    end else if (wa == 3 * NWORDS + 2) begin
      region = RG_MSTAT;
    end
  end
endmodule

// File: rtl/irqst_group.sv
module irqst_group #(
  parameter int NUM_IN  = 128,
  parameter int NUM_OUT = 2
) (
  input  logic [NUM_IN-1:0]  stat,
  output logic [NUM_OUT-1:0] any
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_grp
    localparam int LO = 64 * k;
    localparam int GW = (NUM_IN - LO) < 64 ? (NUM_IN - LO) : 64;
    assign any[k] = |stat[LO +: GW];
  end
endmodule

// File: rtl/irqst_agg.sv
module irqst_agg
  import irqst_pkg::*;
#(
  parameter int NUM_IN   = 128,
  parameter int CHAN_W   = 8,
  parameter int CHAN_SEL = 0,
  parameter int NUM_OUT  = (NUM_IN + 63) / 64,
  parameter int ADDR_W   = $clog2(12 * (NUM_IN / 32) + 12)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  input  logic [NUM_IN-1:0]  irq_in,
  output logic [NUM_OUT-1:0] irq_out
);
  localparam int NWORDS = NUM_IN / 32;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic [NUM_IN-1:0] in_s;
  logic [NUM_IN-1:0] stat_flat;
  logic [NUM_OUT-1:0] grp_any;
  logic [NUM_OUT-1:0] pre_out;
  logic [CHAN_W-1:0]  ctrl_q;
  logic [NUM_OUT-1:0] mdis_q;
  word_t mask_q   [NWORDS];
  word_t force_q  [NWORDS];
  word_t status_q [NWORDS];
  logic wr_en;

  assign wr_en = req_valid && req_write;

  irqst_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(in_s)
  );

  irqst_dec #(.NWORDS(NWORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .region(region), .idx(idx)
  );

  // Control, mask, force and master-disable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mdis_q <= '0;
      for (int w = 0; w < NWORDS; w++) begin
        mask_q[w]  <= '0;
        force_q[w] <= '0;
      end
    end else if (wr_en) begin
      case (region)
        RG_CTRL:  ctrl_q       <= req_wdata[CHAN_W-1:0];
        RG_MASK:  mask_q[idx]  <= req_wdata;
        RG_FORCE: force_q[idx] <= req_wdata;
        RG_MDIS:  mdis_q       <= req_wdata[NUM_OUT-1:0];
        default: ;
      endcase
    end
  end

  // Status words, reversed: word w holds sources (NWORDS-1-w)*32 upward
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int BASE = (NWORDS - 1 - w) * 32;
    always_ff @(posedge clk) begin
      if (rst) status_q[w] <= '0;
      else     status_q[w] <= (in_s[BASE +: 32] | force_q[w]) & mask_q[w];
    end
    assign stat_flat[BASE +: 32] = status_q[w];
  end

  irqst_group #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_grp (
    .stat(stat_flat), .any(grp_any)
  );

  assign pre_out = grp_any & {NUM_OUT{ctrl_q[CHAN_SEL]}};

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= pre_out & ~mdis_q;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        case (region)
          RG_CTRL:  rd_data <= 32'(ctrl_q);
          RG_MASK:  rd_data <= mask_q[idx];
          RG_FORCE: rd_data <= force_q[idx];
          RG_STAT:  rd_data <= status_q[idx];
          RG_MDIS:  rd_data <= 32'(mdis_q);
          RG_MSTAT: rd_data <= 32'(pre_out);
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqst_agg_chk.sv
module irqst_agg_chk #(
  parameter int NUM_OUT  = 2,
  parameter int CHAN_W   = 8,
  parameter int CHAN_SEL = 0
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic               rd_valid,
  input logic [NUM_OUT-1:0] irq_out,
  input logic [NUM_OUT-1:0] mdis_q,
  input logic [CHAN_W-1:0]  ctrl_q
);
  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> irq_out == '0);
  // R11
  read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
  // R11
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rd_valid);
  // R9
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(mdis_q) |-> ((irq_out & $past(mdis_q)) == '0));
  // R4
  channel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_q[CHAN_SEL]) |-> irq_out == '0);
endmodule

bind irqst_agg irqst_agg_chk #(
  .NUM_OUT(NUM_OUT), .CHAN_W(CHAN_W), .CHAN_SEL(CHAN_SEL)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rd_valid(rd_valid), .irq_out(irq_out), .mdis_q(mdis_q), .ctrl_q(ctrl_q)
);

// File: tb/irqst_agg_bench.sv
module irqst_agg_bench;
  localparam int NUM_IN  = 96;
  localparam int NUM_OUT = 2;
  localparam int ADDR_W  = 6;
  localparam int NV      = 38;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IN = 2'd2, K_OUT = 2'd3;

  // {kind, addr, data, expected}
  localparam logic [73:0] VEC [NV] = '{
    {K_RD, 8'h00, 32'h0, 32'h0},          {K_RD, 8'h04, 32'h0, 32'h0},
    {K_RD, 8'h28, 32'h0, 32'h0},          {K_WR, 8'h00, 32'h4, 32'h0},
    {K_RD, 8'h00, 32'h0, 32'h4},          {K_IN, 8'h00, 32'd0, 32'h1},
    {K_RD, 8'h24, 32'h0, 32'h0},          {K_OUT, 8'h00, 32'h0, 32'h0},
    {K_WR, 8'h0C, 32'h1, 32'h0},          {K_RD, 8'h0C, 32'h0, 32'h1},
    {K_RD, 8'h24, 32'h0, 32'h1},          {K_OUT, 8'h00, 32'h0, 32'h1},
    {K_RD, 8'h2C, 32'h0, 32'h1},          {K_WR, 8'h28, 32'h1, 32'h0},
    {K_OUT, 8'h00, 32'h0, 32'h0},         {K_RD, 8'h2C, 32'h0, 32'h1},
    {K_WR, 8'h28, 32'h0, 32'h0},          {K_OUT, 8'h00, 32'h0, 32'h1},
    {K_IN, 8'h00, 32'd0, 32'h0},          {K_RD, 8'h24, 32'h0, 32'h0},
    {K_OUT, 8'h00, 32'h0, 32'h0},         {K_WR, 8'h04, 32'h80000000, 32'h0},
    {K_WR, 8'h10, 32'h80000000, 32'h0},   {K_RD, 8'h1C, 32'h0, 32'h80000000},
    {K_OUT, 8'h00, 32'h0, 32'h2},         {K_RD, 8'h10, 32'h0, 32'h80000000},
    {K_WR, 8'h00, 32'h1, 32'h0},          {K_OUT, 8'h00, 32'h0, 32'h0},
    {K_RD, 8'h2C, 32'h0, 32'h0},          {K_WR, 8'h1C, 32'hFFFFFFFF, 32'h0},
    {K_RD, 8'h1C, 32'h0, 32'h80000000},   {K_IN, 8'h00, 32'd40, 32'h1},
    {K_WR, 8'h08, 32'h100, 32'h0},        {K_RD, 8'h20, 32'h0, 32'h100},
    {K_WR, 8'h00, 32'h4, 32'h0},          {K_OUT, 8'h00, 32'h0, 32'h3},
    {K_RD, 8'h30, 32'h0, 32'h0},          {K_RD, 8'h14, 32'h0, 32'h0}
  };

  string tags [NV];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NUM_IN-1:0] irq_in = '0;
  logic [NUM_OUT-1:0] irq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqst_agg #(.NUM_IN(NUM_IN), .CHAN_W(8), .CHAN_SEL(2)) u_irqst_agg (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: strobe and data one cycle after the request
    check(rd_valid === 1'b1, "R11", 32'(rd_valid), 32'h1);
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    tags = '{"R8", "R8", "R8", "R4", "R4", "R6", "R6", "R6", "R3", "R3",
             "R1", "R7", "R10", "R9", "R9", "R10", "R9", "R9", "R6", "R6",
             "R6", "R3", "R5", "R5", "R7", "R3", "R4", "R4", "R10", "R5",
             "R5", "R1", "R1", "R1", "R4", "R7", "R2", "R2"};
    idle(3);
    rst = 1'b0;
    idle(2);
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      logic [7:0]  a;
      logic [31:0] d, e;
      {k, a, d, e} = VEC[v];
      case (k)
        K_WR: wr(a, d);
        K_RD: rd(a, e, tags[v]);
        K_IN: begin @(negedge clk); irq_in[d] = e[0]; end
        default: check(irq_out === e[NUM_OUT-1:0], tags[v],
                       32'(irq_out), e);
      endcase
      idle(5);
    end

    // R11: source 41 enabled, output 0 rises on the fourth edge
    wr(8'h08, 32'h200);
    irq_in[40] = 1'b0;
    idle(6);
    check(irq_out === 2'b10, "R11", 32'(irq_out), 32'h2);
    @(negedge clk);
    irq_in[41] = 1'b1;
    idle(3);
    check(irq_out[0] === 1'b0, "R11", 32'(irq_out), 32'h2);
    idle(1);
    check(irq_out[0] === 1'b1, "R11", 32'(irq_out), 32'h3);

    // R8: reset in the middle of activity
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check(irq_out === '0, "R8", 32'(irq_out), 32'h0);
    rd(8'h00, 32'h0, "R8");
    rd(8'h08, 32'h0, "R8");
    rd(8'h10, 32'h0, "R8");
    idle(5);
    rd(8'h20, 32'h0, "R8");
    check(irq_out === '0, "R8", 32'(irq_out), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule